// File: doc/BRIEF.md
# Selectable-Length Noise Channel

This block is the noise voice of a small sound generator. It holds one pseudo-random shift register whose length can be switched between 9, 11, 15 and 17 bits while it runs. The register steps on a falling edge of the clock source that has been picked for it. That source is either a slow tick, made by dividing a 250 kHz strobe by eight, or the final output of one of the tone channels. The lowest bit of the register is sent out as a raw random bit, which the tone channels can use as a distortion source. The same bit drives a short shaping chain that ends in the channel's 1-bit output.

The shaping chain has three stages. An optional low-pass stage holds the level of tone channel 2 each time the random bit falls. An optional high-pass stage clears the channel state on a falling edge of a linked channel. An optional ring stage combines the state with another channel through XNOR. The stages always take effect in the order register step, low-pass, high-pass, ring. Everything runs on one system clock, and every slow event arrives as a level or a one-cycle strobe that is sampled on that clock.

Top module: `noise_chan`

## Requirements
- R1: During reset and after it, the register holds all ones within the selected length, `poly_bit` reads 1 and `noise_out` reads 0 while ring mode is off.
- R2: One step shifts the register right by one place. When the bit shifted out is 1, the step also XORs in the mask for the current length. `len_sel` codes 0, 1, 2 and 3 select 9 bits with mask 0x110, 11 bits with 0x500, 15 bits with 0x6000 and 17 bits with 0x12000. `poly_bit` is register bit 0.
- R3: A change of `len_sel` refills the register with all ones of the new length on the next clock edge. A step due on that edge is dropped.
- R4: With `src_sel` = k (1 to 3), the register steps only on a falling edge (1 then 0 on successive clocks) of `tone_out[k-1]`. Rising edges and activity on the other tone inputs are ignored.
- R5: With `src_sel` = 0, the register steps on every eighth `tick_250` strobe, counted from reset, and at no other time.
- R6: With low-pass off, the channel state takes the new `poly_bit` one clock after each step. `poly_bit` changes on the step edge and `noise_out` changes on the edge after it.
- R7: With `lp_en` = 1, each falling edge of `poly_bit` loads the level of `tone_out[2]` into the channel state. Between such edges the state holds, whatever `tone_out[2]` does.
- R8: With `hp_en` = 1, a falling edge of `hp_ref` clears the channel state on the following edge. With `hp_en` = 0, `hp_ref` has no effect.
- R9: With `ring_en` = 1, `noise_out` is the XNOR of the channel state and `ring_ref`, with no register on the way. With `ring_en` = 0, `noise_out` is the channel state.
- R10: When a high-pass clear and a state update fall on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_250 | input | 1 | One-cycle strobe at the 250 kHz rate |
| tone_out | input | NUM_TONES | Final outputs of the tone channels |
| src_sel | input | SEL_W | Clock source: 0 selects the slow tick, k selects tone k-1 |
| len_sel | input | 2 | Register length code |
| lp_en | input | 1 | Low-pass enable |
| hp_en | input | 1 | High-pass enable |
| hp_ref | input | 1 | Linked channel for the high-pass clear |
| ring_en | input | 1 | Ring modulation enable |
| ring_ref | input | 1 | Partner channel for ring modulation |
| noise_out | output | 1 | Channel output |
| poly_bit | output | 1 | Raw random bit (register bit 0) |

## Verification
A source edge presented before clock edge N steps the register on edge N, so `poly_bit` is sampled on the falling clock edge that follows. `noise_out` is only sampled one full cycle later, and one check confirms that it still shows the old state at the earlier sample point. A high-pass fall reaches `noise_out` on the edge after the falling input, and ring mode reaches it a moment after `ring_ref` changes. A slow-tick step lands on the edge where the eighth strobe is high. Every input is driven on a falling clock edge, so each sample lands half a cycle after the edge that should have produced the result.

// File: rtl/nz_pkg.sv
package nz_pkg;

   localparam int NZ_MAX_W = 17;

   function automatic int nz_width(input logic [1:0] sel);
      case (sel)
         2'd0:    return 9;
         2'd1:    return 11;
         2'd2:    return 15;
         default: return 17;
      endcase
   endfunction

   function automatic logic [NZ_MAX_W-1:0] nz_taps(input logic [1:0] sel);
      case (sel)
         2'd0:    return 17'h00110;
         2'd1:    return 17'h00500;
         2'd2:    return 17'h06000;
         default: return 17'h12000;
      endcase
   endfunction

   function automatic logic [NZ_MAX_W-1:0] nz_fill(input logic [1:0] sel);
      return (NZ_MAX_W'(1) << nz_width(sel)) - NZ_MAX_W'(1);
   endfunction

endpackage

// File: rtl/nz_tick_div.sv
module nz_tick_div #(
   parameter int DIV_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);
   generate
      if (DIV_W < 0) begin : g_bad
         $error("nz_tick_div: DIV_W must not be negative");
      end
      if (DIV_W == 0) begin : g_pass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick_out  = tick_in;
      end else begin : g_count
         localparam logic [DIV_W-1:0] LAST = '1;
         logic [DIV_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       cnt_q <= '0;
            else if (tick_in) cnt_q <= cnt_q + 1'b1;
         end
         assign tick_out = tick_in && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/nz_edge_bank.sv
module nz_edge_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] fall
);
   generate
      if (N < 1) begin : g_bad
         $error("nz_edge_bank: N must be at least 1");
      end
      for (genvar g = 0; g < N; g++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk) prev_q <= lvl[g];
         assign fall[g] = prev_q & ~lvl[g];
      end
   endgenerate
endmodule

// File: rtl/nz_poly.sv
module nz_poly
   import nz_pkg::*;
#(
   parameter int MAX_W = NZ_MAX_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic [1:0] len_sel,
   output logic       bit_out
);
   generate
      if (MAX_W != NZ_MAX_W) begin : g_bad
         $error("nz_poly: MAX_W must match the longest selectable length");
      end
   endgenerate

   logic [MAX_W-1:0] sr_q;
   logic [MAX_W-1:0] sr_next;
   logic [1:0]       len_q;

   always_comb begin
      sr_next = sr_q >> 1;
      if (sr_q[0]) sr_next = sr_next ^ nz_taps(len_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= len_sel;
         sr_q  <= nz_fill(len_sel);
      end else if (len_sel != len_q) begin
         len_q <= len_sel;
         sr_q  <= nz_fill(len_sel);
      end else if (step) begin
         sr_q  <= sr_next;
      end
   end

   assign bit_out = sr_q[0];
endmodule

// File: rtl/nz_shaper.sv
module nz_shaper #(
   parameter int OUT_REG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic poly,
   input  logic lp_en,
   input  logic lp_src,
   input  logic hp_en,
   input  logic hp_ref,
   input  logic ring_en,
   input  logic ring_ref,
   output logic out
);
   logic poly_q, hp_q, st_q;
   logic poly_fall, hp_fall, ev, nv;

   always_ff @(posedge clk) begin
      hp_q <= hp_ref;
      if (!rst_n) poly_q <= 1'b1;
      else        poly_q <= poly;
   end

   assign poly_fall = poly_q & ~poly;
   assign hp_fall   = hp_q & ~hp_ref;

   // stage order: step result, low-pass select, high-pass clear
   assign ev = lp_en ? poly_fall : upd;
   assign nv = lp_en ? lp_src    : poly;

   always_ff @(posedge clk) begin
      if (!rst_n)                st_q <= 1'b0;
      else if (hp_en && hp_fall) st_q <= 1'b0;
      else if (ev)               st_q <= nv;
   end

   generate
      if (OUT_REG != 0) begin : g_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= ring_en ? ~(st_q ^ ring_ref) : st_q;
         end
         assign out = out_q;
      end else begin : g_comb
         assign out = ring_en ? ~(st_q ^ ring_ref) : st_q;
      end
   endgenerate
endmodule

// File: rtl/noise_chan.sv
module noise_chan
   import nz_pkg::*;
#(
   parameter int NUM_TONES = 3,
   parameter int LP_TONE   = 2,
   parameter int DIV_W     = 3,
   parameter int SEL_W     = 2,
   parameter int OUT_REG   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_250,
   input  logic [NUM_TONES-1:0] tone_out,
   input  logic [SEL_W-1:0]     src_sel,
   input  logic [1:0]           len_sel,
   input  logic                 lp_en,
   input  logic                 hp_en,
   input  logic                 hp_ref,
   input  logic                 ring_en,
   input  logic                 ring_ref,
   output logic                 noise_out,
   output logic                 poly_bit
);
   generate
      if (LP_TONE < 0 || LP_TONE >= NUM_TONES) begin : g_bad_lp
         $error("noise_chan: LP_TONE out of range");
      end
      if ((1 << SEL_W) < NUM_TONES + 1) begin : g_bad_sel
         $error("noise_chan: SEL_W too narrow for NUM_TONES");
      end
   endgenerate

   logic                 slow_tick;
   logic [NUM_TONES-1:0] tone_fall;
   logic                 step, step_d;

   nz_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (tick_250),
      .tick_out (slow_tick)
   );

   nz_edge_bank #(.N(NUM_TONES)) u_edges (
      .clk  (clk),
      .lvl  (tone_out),
      .fall (tone_fall)
   );

   always_comb begin
      step = 1'b0;
      if (src_sel == '0) step = slow_tick;
      for (int i = 0; i < NUM_TONES; i++)
         if (src_sel == SEL_W'(i + 1)) step = tone_fall[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_d <= 1'b0;
      else        step_d <= step;
   end

   nz_poly #(.MAX_W(NZ_MAX_W)) u_poly (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .len_sel (len_sel),
      .bit_out (poly_bit)
   );

   nz_shaper #(.OUT_REG(OUT_REG)) u_shape (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (step_d),
      .poly     (poly_bit),
      .lp_en    (lp_en),
      .lp_src   (tone_out[LP_TONE]),
      .hp_en    (hp_en),
      .hp_ref   (hp_ref),
      .ring_en  (ring_en),
      .ring_ref (ring_ref),
      .out      (noise_out)
   );
endmodule

// File: rtl/nz_chk.sv
module nz_chk #(
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_250,
   input logic             tone0,
   input logic [SEL_W-1:0] src_sel,
   input logic [1:0]       len_sel,
   input logic             lp_en,
   input logic             hp_en,
   input logic             hp_ref,
   input logic             ring_en,
   input logic             noise_out,
   input logic             poly_bit
);
   AST_LEN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(len_sel) |=> poly_bit);                                   // R3

   AST_TONE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == SEL_W'(1)) && !($past(tone0) && !tone0) && $stable(len_sel)
      |=> $stable(poly_bit));                                            // R4

   AST_SLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == '0) && !tick_250 && $stable(len_sel)
      |=> $stable(poly_bit));                                            // R5

   AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lp_en && !hp_en && !ring_en && !($past(poly_bit) && !poly_bit)
      |=> ring_en || $stable(noise_out));                                // R7

   AST_HP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hp_en && $past(hp_ref) && !hp_ref |=> ring_en || !noise_out);      // R8
endmodule

bind noise_chan nz_chk #(.SEL_W(SEL_W)) i_nz_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_250  (tick_250),
   .tone0     (tone_out[0]),
   .src_sel   (src_sel),
   .len_sel   (len_sel),
   .lp_en     (lp_en),
   .hp_en     (hp_en),
   .hp_ref    (hp_ref),
   .ring_en   (ring_en),
   .noise_out (noise_out),
   .poly_bit  (poly_bit)
);

// File: tb/test_noise_chan.sv
`timescale 1ns/1ps
module test_noise_chan;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_250 = 1'b0;
   logic [2:0] tone_out = '0;
   logic [1:0] src_sel = 2'd1;
   logic [1:0] len_sel = 2'd0;
   logic       lp_en = 1'b0, hp_en = 1'b0, hp_ref = 1'b0;
   logic       ring_en = 1'b0, ring_ref = 1'b0;
   logic       noise_out, poly_bit;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [16:0] m;
   logic        exp_st;

   always #2.5 clk = ~clk;

   noise_chan i_noise_chan (
      .clk(clk), .rst_n(rst_n), .tick_250(tick_250), .tone_out(tone_out),
      .src_sel(src_sel), .len_sel(len_sel), .lp_en(lp_en), .hp_en(hp_en),
      .hp_ref(hp_ref), .ring_en(ring_en), .ring_ref(ring_ref),
      .noise_out(noise_out), .poly_bit(poly_bit)
   );

   // stimulus vectors: [6:5] length code, [4:0] number of steps
   localparam logic [6:0] VEC [6] = '{
      {2'd1, 5'd20}, {2'd2, 5'd20}, {2'd3, 5'd24},
      {2'd0, 5'd16}, {2'd2, 5'd12}, {2'd1, 5'd8}
   };

   function automatic logic [16:0] m_mask(input logic [1:0] l);
      case (l)
         2'd0: return 17'h00110;
         2'd1: return 17'h00500;
         2'd2: return 17'h06000;
         default: return 17'h12000;
      endcase
   endfunction

   function automatic logic [16:0] m_fill(input logic [1:0] l);
      case (l)
         2'd0: return 17'h001FF;
         2'd1: return 17'h007FF;
         2'd2: return 17'h07FFF;
         default: return 17'h1FFFF;
      endcase
   endfunction

   function automatic logic [16:0] m_next(input logic [16:0] s, input logic [1:0] l);
      return (s >> 1) ^ (s[0] ? m_mask(l) : 17'h0);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_250 = 1'b0; tone_out = '0; src_sel = 2'd1; len_sel = 2'd0;
      lp_en = 1'b0; hp_en = 1'b0; hp_ref = 1'b0; ring_en = 1'b0; ring_ref = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m = m_fill(2'd0);
      exp_st = 1'b0;
   endtask

   // ends on the falling clock edge right after the stepping edge
   task automatic pulse_tone(input int idx);
      @(negedge clk) tone_out[idx] = 1'b1;
      @(negedge clk) tone_out[idx] = 1'b0;
      @(negedge clk);
   endtask

   task automatic tick_once();
      @(negedge clk) tick_250 = 1'b1;
      @(negedge clk) tick_250 = 1'b0;
   endtask

   task automatic pulse_hp();
      @(negedge clk) hp_ref = 1'b1;
      @(negedge clk) hp_ref = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      @(negedge clk);
      chk("R1 poly_bit after reset", poly_bit, 1);
      chk("R1 noise_out after reset", noise_out, 0);

      // R2, R3, R6: vector table across all lengths
      for (int v = 0; v < 6; v++) begin
         logic [1:0] nl;
         int ns;
         nl = VEC[v][6:5];
         ns = int'(VEC[v][4:0]);
         @(negedge clk) len_sel = nl;
         @(negedge clk);
         m = m_fill(nl);
         chk("R3 refill on length change", poly_bit, 1);
         for (int s = 0; s < ns; s++) begin
            pulse_tone(0);
            m = m_next(m, nl);
            chk("R2 step value", poly_bit, m[0]);
            chk("R6 state not yet updated", noise_out, exp_st);
            @(negedge clk);
            exp_st = m[0];
            chk("R6 state follows step", noise_out, exp_st);
         end
      end

      // R4: unselected tone and rising edges ignored
      do_reset();
      for (int k = 0; k < 4; k++) begin
         pulse_tone(1);
         chk("R4 other tone ignored", poly_bit, 1);
      end
      @(negedge clk) tone_out[0] = 1'b1;
      @(negedge clk);
      chk("R4 rising edge ignored", poly_bit, 1);
      for (int k = 0; k < 5; k++) begin
         pulse_tone(0);
         m = m_next(m, 2'd0);
         chk("R4 selected tone steps", poly_bit, m[0]);
      end
      chk("R4 fifth step gives zero", poly_bit, 0);

      // R5: slow tick every eighth strobe
      do_reset();
      @(negedge clk) src_sel = 2'd0;
      for (int t = 1; t <= 48; t++) begin
         tick_once();
         if (t % 8 == 0) m = m_next(m, 2'd0);
         chk("R5 slow tick stepping", poly_bit, m[0]);
      end
      pulse_tone(0);
      chk("R5 tone ignored with slow source", poly_bit, m[0]);

      // R7: low-pass sampling of tone 2 on falling random bit
      do_reset();
      @(negedge clk) begin tone_out[2] = 1'b1; lp_en = 1'b1; end
      for (int s = 1; s <= 14; s++) begin
         logic ob;
         if (s == 6) tone_out[2] = 1'b0;
         if (s == 11) tone_out[2] = 1'b1;
         pulse_tone(0);
         ob = m[0];
         m = m_next(m, 2'd0);
         if (ob && !m[0]) exp_st = tone_out[2];
         @(negedge clk);
         chk("R7 low-pass state", noise_out, exp_st);
      end

      // R8, R9, R10: high-pass, ring and priority
      do_reset();
      pulse_tone(0);
      m = m_next(m, 2'd0);
      @(negedge clk);
      chk("R6 state set by step", noise_out, 1);
      pulse_hp();
      chk("R8 hp_ref ignored when off", noise_out, 1);
      @(negedge clk) hp_en = 1'b1;
      pulse_hp();
      chk("R8 falling hp_ref clears", noise_out, 0);
      @(negedge clk) begin ring_en = 1'b1; ring_ref = 1'b0; end
      #1 chk("R9 ring xnor 0,0", noise_out, 1);
      @(negedge clk) ring_ref = 1'b1;
      #1 chk("R9 ring xnor 0,1", noise_out, 0);
      @(negedge clk) begin ring_en = 1'b0; ring_ref = 1'b0; end
      @(negedge clk) begin tone_out[0] = 1'b1; hp_ref = 1'b1; end
      @(negedge clk) tone_out[0] = 1'b0;
      @(negedge clk) hp_ref = 1'b0;
      m = m_next(m, 2'd0);
      @(negedge clk);
      chk("R10 random bit is one", poly_bit, m[0]);
      chk("R10 clear wins over update", noise_out, 0);
      pulse_tone(0);
      m = m_next(m, 2'd0);
      @(negedge clk);
      chk("R10 next update applies", noise_out, m[0]);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule